// File: doc/BRIEF.md
# BPSK Carrier Synthesizer with Phase-Domain Modulation

This block builds a sampled sine carrier by direct digital synthesis and keys it with binary phase shift keying. A wide phase register advances by a programmable step every enabled clock, so the carrier frequency is set by that step word alone. A half-turn phase offset, chosen by a data bit, is added to the phase before it is turned into an amplitude. The sine amplitude comes from a table that holds only one quadrant of the wave. The phase is folded onto that quadrant, and the sign is restored afterwards.

The data bit is captured only when a symbol strobe is high, so the carrier phase flips only on symbol boundaries. Each enabled clock produces one signed sample a fixed number of cycles later, marked by a valid flag. The table contents depend only on the address and amplitude widths. A new frequency word needs no new table contents.

Top module: `bpsk_dds_mod`

## Requirements
- R1: While `rst` is high, `valid_o` is 0 and `sample_o` is 0. After reset the phase register and the latched data bit are 0, so the first enabled sample uses phase 0.
- R2: On each rising edge with `en_i` high, the 32-bit phase register advances by `fcw_i`, modulo 2^32. With `en_i` low it holds its value.
- R3: The lookup phase is the register's top 12 bits plus 0x800 when the latched data bit is 1, or plus 0 when it is 0, taken modulo 4096. This is a half-turn shift.
- R4: The latched data bit takes `data_i` only on edges where `sym_stb_i` is high. Changes of `data_i` at any other time have no effect on the output.
- R5: Folding rule. Bits [11:10] of the lookup phase form the quadrant q, and bits [9:0] form the address a. The table index is a when q[0]=0, and the bitwise inverse of a (1023−a) when q[0]=1. The sample is +T[index] when q[1]=0 and −T[index] when q[1]=1.
- R6: The table entry is T[k] = floor(32767·sin(π·(2k+1)/4096) + 0.5) for k = 0..1023. The output is never −32768.
- R7: A sample computed from the phase and data state present at a rising edge with `en_i` high appears with `valid_o` high right after the second rising edge that follows. This is three registered stages counted from that edge. `valid_o` is low for edges where `en_i` was low.
- R8: While `valid_o` is low, `sample_o` keeps its last valid value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Advance phase and emit one sample this cycle |
| fcw_i | input | 32 | Frequency control word (phase step per clock) |
| sym_stb_i | input | 1 | Symbol strobe: capture `data_i` |
| data_i | input | 1 | Modulating data bit (1 = half-turn shift) |
| sample_o | output | 16 | Signed carrier sample |
| valid_o | output | 1 | `sample_o` holds a new sample |

## Verification
The assertions assume that reset is held for at least one clock. They also assume that all inputs, including `fcw_i`, are stable at the rising edge; no particular strobe spacing or word range is assumed. The stimulus drives all inputs on the falling edge. It holds reset for several cycles and then mixes random enable, strobe and data patterns with arbitrary 32-bit frequency words, including 0 and all ones. Directed runs then pin down quadrant stepping, wrap-around and strobe gating.

// File: rtl/bpsk_dds_pkg.sv
package bpsk_dds_pkg;

    localparam int DEF_ACC_W  = 32;
    localparam int DEF_ADDR_W = 10;
    localparam int DEF_AMP_W  = 16;

    // Quadrant of the folded phase, in order of increasing phase
    typedef enum logic [1:0] {
        QD_RISE     = 2'b00,
        QD_FALL     = 2'b01,
        QD_NEG_FALL = 2'b10,
        QD_NEG_RISE = 2'b11
    } quadrant_e;

    function automatic logic quad_mirror(input quadrant_e q);
        return (q == QD_FALL) || (q == QD_NEG_RISE);
    endfunction

    function automatic logic quad_negate(input quadrant_e q);
        return (q == QD_NEG_FALL) || (q == QD_NEG_RISE);
    endfunction

    // Quarter-wave magnitude at the centre of slot k
    function automatic int qw_entry(input int k, input int addr_w, input int amp_w);
        real pi_v;
        real ang;
        real peak;
        pi_v = 3.14159265358979323846;
        ang  = pi_v * (2.0 * k + 1.0) / (2.0 ** (addr_w + 2));
        peak = (2.0 ** (amp_w - 1)) - 1.0;
        return $rtoi(peak * $sin(ang) + 0.5);
    endfunction

endpackage

// File: rtl/bpsk_phase_acc.sv
module bpsk_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [ACC_W-1:0] fcw_i,
    input  logic             sym_stb_i,
    input  logic             data_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             data_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_o  <= '0;
            data_o <= 1'b0;
        end else begin
            if (en_i)
                acc_o <= acc_o + fcw_i;
            if (sym_stb_i)
                data_o <= data_i;
        end
    end

endmodule

// File: rtl/bpsk_phase_fold.sv
module bpsk_phase_fold
    import bpsk_dds_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic [ACC_W-1:0]  acc_i,
    input  logic              data_i,
    output logic              vld_o,
    output logic              neg_o,
    output logic [ADDR_W-1:0] idx_o
);

    localparam int PH_W = ADDR_W + 2;

    logic [PH_W-1:0]   ph_raw;
    logic [PH_W-1:0]   ph_off;
    logic [PH_W-1:0]   ph_mod;
    quadrant_e         quad;
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] idx_n;

    always_comb begin
        ph_raw = acc_i[ACC_W-1 -: PH_W];
        ph_off = {data_i, {(PH_W-1){1'b0}}};
        ph_mod = ph_raw + ph_off;
        quad   = quadrant_e'(ph_mod[PH_W-1 -: 2]);
        addr   = ph_mod[ADDR_W-1:0];
        idx_n  = quad_mirror(quad) ? ~addr : addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            neg_o <= 1'b0;
            idx_o <= '0;
        end else begin
            vld_o <= en_i;
            neg_o <= quad_negate(quad);
            idx_o <= idx_n;
        end
    end

endmodule

// File: rtl/bpsk_qw_rom.sv
module bpsk_qw_rom
    import bpsk_dds_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int AMP_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_i,
    input  logic              neg_i,
    input  logic [ADDR_W-1:0] idx_i,
    output logic              vld_o,
    output logic              neg_o,
    output logic [AMP_W-2:0]  mag_o
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int MAG_W = AMP_W - 1;

    logic [MAG_W-1:0] table_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign table_w[g] = MAG_W'(qw_entry(g, ADDR_W, AMP_W));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            neg_o <= 1'b0;
            mag_o <= '0;
        end else begin
            vld_o <= vld_i;
            neg_o <= neg_i;
            mag_o <= table_w[idx_i];
        end
    end

endmodule

// File: rtl/bpsk_dds_mod.sv
module bpsk_dds_mod
    import bpsk_dds_pkg::*;
#(
    parameter int ACC_W  = DEF_ACC_W,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int AMP_W  = DEF_AMP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic [ACC_W-1:0] fcw_i,
    input  logic             sym_stb_i,
    input  logic             data_i,
    output logic [AMP_W-1:0] sample_o,
    output logic             valid_o
);

    logic [ACC_W-1:0]  acc_w;
    logic              data_w;
    logic              vld1;
    logic              neg1;
    logic [ADDR_W-1:0] idx1;
    logic              vld2;
    logic              neg2;
    logic [AMP_W-2:0]  mag2;
    logic signed [AMP_W-1:0] mag_s;

    bpsk_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en_i),
        .fcw_i     (fcw_i),
        .sym_stb_i (sym_stb_i),
        .data_i    (data_i),
        .acc_o     (acc_w),
        .data_o    (data_w)
    );

    bpsk_phase_fold #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_fold (
        .clk    (clk),
        .rst    (rst),
        .en_i   (en_i),
        .acc_i  (acc_w),
        .data_i (data_w),
        .vld_o  (vld1),
        .neg_o  (neg1),
        .idx_o  (idx1)
    );

    bpsk_qw_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
        .clk   (clk),
        .rst   (rst),
        .vld_i (vld1),
        .neg_i (neg1),
        .idx_i (idx1),
        .vld_o (vld2),
        .neg_o (neg2),
        .mag_o (mag2)
    );

    assign mag_s = $signed({1'b0, mag2});

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= vld2;
            if (vld2)
                sample_o <= neg2 ? (-mag_s) : mag_s;
        end
    end

endmodule

// File: rtl/bpsk_dds_mod_chk.sv
module bpsk_dds_mod_chk #(
    parameter int ACC_W = 32,
    parameter int AMP_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             en_i,
    input logic [ACC_W-1:0] fcw_i,
    input logic             sym_stb_i,
    input logic [ACC_W-1:0] acc,
    input logic             data_q,
    input logic [AMP_W-1:0] sample_o,
    input logic             valid_o
);

    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)
            age <= 2'd0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    // R2
    acc_step_chk: assert property (@(posedge clk) disable iff (rst)
        en_i |=> (acc == $past(acc) + $past(fcw_i)));

    // R2
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> $stable(acc));

    // R4
    data_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !sym_stb_i |=> $stable(data_q));

    // R6
    no_minneg_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (sample_o != {1'b1, {(AMP_W-1){1'b0}}}));

    // R7
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (valid_o == $past(en_i, 3)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(sample_o));

endmodule

bind bpsk_dds_mod bpsk_dds_mod_chk #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en_i),
    .fcw_i     (fcw_i),
    .sym_stb_i (sym_stb_i),
    .acc       (acc_w),
    .data_q    (data_w),
    .sample_o  (sample_o),
    .valid_o   (valid_o)
);

// File: tb/bpsk_dds_mod_tb.sv
module bpsk_dds_mod_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_i = 1'b0;
    logic [31:0] fcw_i = '0;
    logic        sym_stb_i = 1'b0;
    logic        data_i = 1'b0;
    logic [15:0] sample_o;
    logic        valid_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // bench model state
    logic [31:0] macc;
    logic        mdata;
    logic        pv [3];
    logic [11:0] pph [3];
    int          last_s;
    string       tag;

    always #4 clk = ~clk;

    bpsk_dds_mod u_dut (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en_i),
        .fcw_i     (fcw_i),
        .sym_stb_i (sym_stb_i),
        .data_i    (data_i),
        .sample_o  (sample_o),
        .valid_o   (valid_o)
    );

    function automatic int tbl(input int k);
        real ang;
        ang = 3.14159265358979323846 * (2.0 * k + 1.0) / 4096.0;
        return $rtoi(32767.0 * $sin(ang) + 0.5);
    endfunction

    function automatic int exp_sample(input logic [11:0] ph);
        int q;
        int a;
        int idx;
        int m;
        q   = int'(ph[11:10]);
        a   = int'(ph[9:0]);
        idx = (q % 2 == 1) ? (1023 - a) : a;
        m   = tbl(idx);
        return (q >= 2) ? -m : m;
    endfunction

    task automatic check(input string t, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", t, act, expv, $time);
        end
    endtask

    task automatic cyc(input logic r, input logic en, input logic stb,
                       input logic d, input logic [31:0] f);
        logic [11:0] ph;
        int act;
        @(negedge clk);
        rst = r; en_i = en; sym_stb_i = stb; data_i = d; fcw_i = f;
        @(posedge clk);
        if (r) begin
            macc = '0; mdata = 1'b0; last_s = 0;
            for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; pph[i] = '0; end
        end else begin
            ph = macc[31:20] + (mdata ? 12'h800 : 12'h000);
            pv[2] = pv[1]; pph[2] = pph[1];
            pv[1] = pv[0]; pph[1] = pph[0];
            pv[0] = en;    pph[0] = ph;
            if (en) macc = macc + f;
            if (stb) mdata = d;
        end
        #1;
        act = int'($signed(sample_o));
        if (r) begin
            check("R1 valid", int'(valid_o), 0);
            check("R1 sample", act, 0);
        end else begin
            check("R7 valid", int'(valid_o), int'(pv[2]));
            if (pv[2]) begin
                check(tag, act, exp_sample(pph[2]));
                last_s = exp_sample(pph[2]);
            end else begin
                check("R8 hold", act, last_s);
            end
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [31:0] f;
        seed = $urandom(32'd2024);
        tag = "R1";
        for (int i = 0; i < 4; i++) cyc(1, 1, 1, 1, 32'h1234);
        // R1: first samples come from phase 0
        for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 32'd0);
        // R3: half-turn offset with data 1
        tag = "R3";
        cyc(0, 1, 1, 1, 32'd0);
        for (int i = 0; i < 5; i++) cyc(0, 1, 0, 1, 32'd0);
        // R4: data toggles without a strobe are ignored
        tag = "R4";
        for (int i = 0; i < 8; i++) cyc(0, 1, 0, i[0], 32'd0);
        // R2: one table step per clock, pause, wrap with all-ones word
        tag = "R2";
        for (int i = 0; i < 12; i++) cyc(0, 1, 0, 0, 32'h0010_0000);
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 32'h0010_0000);
        for (int i = 0; i < 10; i++) cyc(0, 1, 0, 0, 32'hFFFF_FFFF);
        for (int i = 0; i < 6; i++) cyc(0, 1, 0, 0, 32'hFFF0_0000);
        // R5: quadrant stepping at a fixed address, both data values
        tag = "R5";
        cyc(0, 1, 0, 0, 32'h1234_5678);
        for (int i = 0; i < 10; i++) cyc(0, 1, (i == 5), 1, 32'h4000_0000);
        cyc(0, 1, 1, 0, 32'h0000_0000);
        for (int i = 0; i < 8; i++) cyc(0, 1, 0, 0, 32'h0000_0000);
        // R6: random words, enables, strobes and data
        tag = "R6";
        f = $urandom();
        for (int i = 0; i < 2500; i++) begin
            int r;
            r = $urandom_range(0, 15);
            if (r == 0) f = $urandom();
            else if (r == 1) f = 32'hFFFF_FFFF;
            else if (r == 2) f = $urandom_range(0, 4095);
            cyc(0, ($urandom_range(0, 3) != 0), ($urandom_range(0, 4) == 0),
                1'($urandom_range(0, 1)), f);
        end
        // R1: reset mid-stream returns outputs to zero
        tag = "R1";
        cyc(1, 1, 1, 1, 32'h5555_5555);
        cyc(1, 0, 0, 0, 32'd0);
        for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 32'h0800_0000);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule